// File: doc/BRIEF.md
# SIMD Lane Placement Mapper

This block works out where each data element belongs when several short vectors share one wide circular rotator of `N_LANES` lanes. At run time it is given a vector count T and a vector length m with T·m ≤ `N_LANES`. Element i of vector k is first placed at combined position j = i·T + k of a merged vector of length M = T·m. That combined position is then spread evenly over the lanes as lane floor(j·N_LANES/M). Lanes that receive no element stay idle. With this layout, rotating the merged vector by p·T rotates every one of the T vectors by p, so the mapper also returns that combined rotation amount for the stage that drives the rotator.

The block serves the memory load and unload paths. Requests arrive one per cycle with a valid/ready handshake. A forward request turns (k, i) into a lane number. An inverse request turns a lane number back into (k, i), or flags the lane as idle. Results are registered and appear one cycle after acceptance. A configuration write takes one extra cycle to settle, and the block refuses requests during that cycle.

Top module: `simd_lane_mapper`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and the active configuration is T=1 with m=N_LANES.
- R2: A forward request (in_inv=0) with in_vec=k<T and in_elem=i<m returns out_lane = floor((i·T+k)·N_LANES/(T·m)) and out_idle=0. For example, with N_LANES=8, T=1 and m=5, elements 0..4 go to lanes 0,1,3,4,6. With T=2 and m=3, the combined order is vector 0 element 0, vector 1 element 0, vector 0 element 1, and so on.
- R3: A forward request with k≥T or i≥m returns out_idle=1.
- R4: An inverse request (in_inv=1) on a lane that some element maps to under R2 returns that element's k on out_vec and i on out_elem, with out_idle=0.
- R5: An inverse request on a lane that no element maps to returns out_idle=1.
- R6: Every result carries out_rot = in_rot·T, the merged-vector rotation for a per-vector rotation in_rot < m.
- R7: A cycle in which cfg_we is high is followed by exactly one cycle with in_ready=0, provided cfg_we is not high again.
- R8: A configuration write with T=0, m=0 or T·m > N_LANES is ignored, and the previous configuration stays in use. It still causes the not-ready cycle of R7.
- R9: out_valid is 1 in the cycle after a request is accepted (in_valid and in_ready both high at a clock edge), and 0 otherwise. A request accepted in the same cycle as cfg_we uses the old configuration.
- R10: A request offered while in_ready is 0 produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write a new T and m |
| cfg_t | input | CW | Vector count T |
| cfg_m | input | CW | Vector length m |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_inv | input | 1 | 0: coordinate to lane, 1: lane to coordinate |
| in_vec | input | LW | Vector index k (forward) |
| in_elem | input | LW | Element index i (forward) |
| in_lane | input | LW | Lane number (inverse) |
| in_rot | input | LW | Per-vector rotation p |
| out_valid | output | 1 | Result present |
| out_lane | output | LW | Lane number |
| out_vec | output | LW | Vector index k |
| out_elem | output | LW | Element index i |
| out_idle | output | 1 | Coordinate out of range or lane unused |
| out_rot | output | LW | Merged rotation p·T |

## Verification
Every mapping result is due exactly one clock edge after acceptance. The bench drives a request on a falling edge, lets one rising edge pass, and reads the outputs at the next falling edge. The not-ready window after a configuration write is read at the first falling edge after the write edge, and recovery is read one edge later. A request offered inside that window is checked by confirming that out_valid stays low one edge after it.

// File: rtl/lane_map_pkg.sv
package lane_map_pkg;
  typedef enum logic {DIR_FWD = 1'b0, DIR_INV = 1'b1} dir_e;
endpackage

// File: rtl/lane_spread_fwd.sv
module lane_spread_fwd #(
  parameter int N_LANES = 8,
  parameter int LW = $clog2(N_LANES),
  parameter int CW = $clog2(N_LANES + 1)
) (
  input  logic [CW-1:0] t,
  input  logic [CW-1:0] m,
  input  logic [CW-1:0] mm,
  input  logic [LW-1:0] k,
  input  logic [LW-1:0] i,
  output logic [LW-1:0] lane,
  output logic          idle
);
  localparam int PW = 3 * CW + 1;
  logic [PW-1:0] pos, scaled, quot;

  always_comb begin
    pos    = PW'(i) * PW'(t) + PW'(k);
    scaled = pos * PW'(N_LANES);
    quot   = scaled / PW'(mm);
    lane   = LW'(quot);
    idle   = (CW'(k) >= t) || (CW'(i) >= m);
  end
endmodule

// File: rtl/lane_spread_inv.sv
module lane_spread_inv #(
  parameter int N_LANES = 8,
  parameter int LW = $clog2(N_LANES),
  parameter int CW = $clog2(N_LANES + 1)
) (
  input  logic [CW-1:0] t,
  input  logic [CW-1:0] mm,
  input  logic [LW-1:0] lane,
  output logic [LW-1:0] k,
  output logic [LW-1:0] i,
  output logic          idle
);
  localparam int PW = 3 * CW + 1;
  logic [PW-1:0] cand, back, kw, iw;

  always_comb begin
    // smallest combined position whose lane is not below this lane
    cand = (PW'(lane) * PW'(mm) + PW'(N_LANES - 1)) / PW'(N_LANES);
    back = (cand * PW'(N_LANES)) / PW'(mm);
    kw   = cand % PW'(t);
    iw   = cand / PW'(t);
    k    = LW'(kw);
    i    = LW'(iw);
    idle = (cand >= PW'(mm)) || (back != PW'(lane));
  end
endmodule

// File: rtl/simd_lane_mapper.sv
module simd_lane_mapper #(
  parameter int N_LANES = 8,
  parameter int LW = $clog2(N_LANES),
  parameter int CW = $clog2(N_LANES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_t,
  input  logic [CW-1:0] cfg_m,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_inv,
  input  logic [LW-1:0] in_vec,
  input  logic [LW-1:0] in_elem,
  input  logic [LW-1:0] in_lane,
  input  logic [LW-1:0] in_rot,
  output logic          out_valid,
  output logic [LW-1:0] out_lane,
  output logic [LW-1:0] out_vec,
  output logic [LW-1:0] out_elem,
  output logic          out_idle,
  output logic [LW-1:0] out_rot
);
  import lane_map_pkg::*;

  localparam int QW = 2 * CW;

  logic [CW-1:0] t_q, m_q, mm_q;
  logic          busy_q;
  logic          cfg_legal;
  logic [QW-1:0] cfg_prod;
  logic          take;
  dir_e          dir;

  logic [LW-1:0] f_lane, r_vec, r_elem;
  logic          f_idle, r_idle;
  logic [QW-1:0] rot_w;

  assign cfg_prod  = QW'(cfg_t) * QW'(cfg_m);
  assign cfg_legal = (cfg_t != '0) && (cfg_m != '0) && (cfg_prod <= QW'(N_LANES));
  assign in_ready  = !busy_q;
  assign take      = in_valid && !busy_q;
  assign dir       = dir_e'(in_inv);
  assign rot_w     = QW'(in_rot) * QW'(t_q);

  lane_spread_fwd #(.N_LANES(N_LANES), .LW(LW), .CW(CW)) u_fwd (
    .t(t_q), .m(m_q), .mm(mm_q), .k(in_vec), .i(in_elem),
    .lane(f_lane), .idle(f_idle)
  );

  lane_spread_inv #(.N_LANES(N_LANES), .LW(LW), .CW(CW)) u_inv (
    .t(t_q), .mm(mm_q), .lane(in_lane),
    .k(r_vec), .i(r_elem), .idle(r_idle)
  );

  // configuration: latch on write, derive the product during the busy cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      t_q    <= CW'(1);
      m_q    <= CW'(N_LANES);
      mm_q   <= CW'(N_LANES);
      busy_q <= 1'b0;
    end else if (cfg_we) begin
      busy_q <= 1'b1;
      if (cfg_legal) begin
        t_q <= cfg_t;
        m_q <= cfg_m;
      end
    end else if (busy_q) begin
      mm_q   <= CW'(QW'(t_q) * QW'(m_q));
      busy_q <= 1'b0;
    end
  end

  // registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_lane  <= '0;
      out_vec   <= '0;
      out_elem  <= '0;
      out_idle  <= 1'b0;
      out_rot   <= '0;
    end else begin
      out_valid <= take;
      if (take) begin
        out_rot <= LW'(rot_w);
        if (dir == DIR_FWD) begin
          out_lane <= f_lane;
          out_vec  <= in_vec;
          out_elem <= in_elem;
          out_idle <= f_idle;
        end else begin
          out_lane <= in_lane;
          out_vec  <= r_vec;
          out_elem <= r_elem;
          out_idle <= r_idle;
        end
      end
    end
  end
endmodule

// File: rtl/simd_lane_mapper_chk.sv
module simd_lane_mapper_chk #(
  parameter int LW = 3,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_inv,
  input logic [LW-1:0] in_vec,
  input logic [CW-1:0] t_q,
  input logic          out_valid,
  input logic          out_idle
);
  AST_RESULT_FROM_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready)); // R9
  AST_ACCEPT_GIVES_RESULT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R9
  AST_CFG_BLOCKS_READY: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> !in_ready); // R7
  AST_READY_RETURNS: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !cfg_we) |=> in_ready); // R7
  AST_BAD_VEC_IDLE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_inv && (CW'(in_vec) >= t_q)) |=> out_idle); // R3
endmodule

bind simd_lane_mapper simd_lane_mapper_chk #(.LW(LW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .in_valid(in_valid),
  .in_ready(in_ready), .in_inv(in_inv), .in_vec(in_vec), .t_q(t_q),
  .out_valid(out_valid), .out_idle(out_idle)
);

// File: tb/simd_lane_mapper_tb.sv
module simd_lane_mapper_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int LW = $clog2(N);
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [CW-1:0] cfg_t = '0, cfg_m = '0;
  logic in_valid = 1'b0, in_inv = 1'b0;
  logic [LW-1:0] in_vec = '0, in_elem = '0, in_lane = '0, in_rot = '0;
  logic in_ready, out_valid, out_idle;
  logic [LW-1:0] out_lane, out_vec, out_elem, out_rot;

  int n_chk = 0;
  int n_bad = 0;
  int cur_t = 1;
  int cur_m = N;

  always #(CLK_PERIOD / 2) clk = ~clk;

  simd_lane_mapper #(.N_LANES(N)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_t(cfg_t), .cfg_m(cfg_m),
    .in_valid(in_valid), .in_ready(in_ready), .in_inv(in_inv),
    .in_vec(in_vec), .in_elem(in_elem), .in_lane(in_lane), .in_rot(in_rot),
    .out_valid(out_valid), .out_lane(out_lane), .out_vec(out_vec),
    .out_elem(out_elem), .out_idle(out_idle), .out_rot(out_rot)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input int t, input int m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_t = CW'(t); cfg_m = CW'(m);
    @(negedge clk);
    cfg_we = 1'b0;
    check("R7 ready low after cfg", int'(in_ready), 0);
    @(negedge clk);
    check("R7 ready back", int'(in_ready), 1);
    if (t != 0 && m != 0 && t * m <= N) begin
      cur_t = t; cur_m = m;
    end
  endtask

  task automatic send(input bit inv, input int k, input int i, input int lane, input int p);
    @(negedge clk);
    in_valid = 1'b1; in_inv = inv;
    in_vec = LW'(k); in_elem = LW'(i); in_lane = LW'(lane); in_rot = LW'(p);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 out_valid after accept", int'(out_valid), 1);
  endtask

  task automatic t_reset();
    check("R1 out_valid at reset", int'(out_valid), 0);
    check("R1 ready at reset", int'(in_ready), 1);
    send(1'b0, 0, 5, 0, 0);
    check("R1 default config lane", int'(out_lane), 5);
  endtask

  task automatic t_fwd_sweep(input int t, input int m);
    write_cfg(t, m);
    for (int k = 0; k < t; k++)
      for (int i = 0; i < m; i++) begin
        send(1'b0, k, i, 0, 0);
        check("R2 forward lane", int'(out_lane), ((i * t + k) * N) / (t * m));
        check("R2 forward not idle", int'(out_idle), 0);
      end
  endtask

  task automatic t_inv_sweep(input int t, input int m);
    write_cfg(t, m);
    for (int lane = 0; lane < N; lane++) begin
      int hit = -1;
      for (int j = 0; j < t * m; j++)
        if ((j * N) / (t * m) == lane) hit = j;
      send(1'b1, 0, 0, lane, 0);
      if (hit < 0) begin
        check("R5 unused lane idle", int'(out_idle), 1);
      end else begin
        check("R4 inverse not idle", int'(out_idle), 0);
        check("R4 inverse vec", int'(out_vec), hit % t);
        check("R4 inverse elem", int'(out_elem), hit / t);
      end
    end
  endtask

  task automatic t_known_examples();
    int exp5[5] = '{0, 1, 3, 4, 6};
    write_cfg(1, 5);
    for (int i = 0; i < 5; i++) begin
      send(1'b0, 0, i, 0, 0);
      check("R2 spread 5 over 8", int'(out_lane), exp5[i]);
    end
    write_cfg(2, 3);
    send(1'b0, 1, 0, 0, 0);
    check("R2 interleave k1 i0", int'(out_lane), 1);
    send(1'b0, 0, 1, 0, 0);
    check("R2 interleave k0 i1", int'(out_lane), 2);
  endtask

  task automatic t_out_of_range();
    write_cfg(2, 3);
    send(1'b0, 2, 0, 0, 0);
    check("R3 vec out of range idle", int'(out_idle), 1);
    send(1'b0, 0, 3, 0, 0);
    check("R3 elem out of range idle", int'(out_idle), 1);
  endtask

  task automatic t_rot();
    write_cfg(2, 4);
    for (int p = 0; p < 4; p++) begin
      send(1'b0, 0, 0, 0, p);
      check("R6 merged rotation", int'(out_rot), p * 2);
    end
    write_cfg(3, 2);
    send(1'b1, 0, 0, 3, 1);
    check("R6 merged rotation inverse", int'(out_rot), 3);
  endtask

  task automatic t_illegal();
    write_cfg(2, 3);
    write_cfg(3, 3);
    send(1'b0, 1, 2, 0, 0);
    check("R8 oversize cfg ignored", int'(out_lane), (5 * N) / 6);
    write_cfg(0, 4);
    send(1'b0, 1, 2, 0, 0);
    check("R8 zero T ignored", int'(out_lane), (5 * N) / 6);
    write_cfg(4, 0);
    send(1'b0, 1, 2, 0, 0);
    check("R8 zero m ignored", int'(out_lane), (5 * N) / 6);
  endtask

  task automatic t_blocked();
    @(negedge clk);
    cfg_we = 1'b1; cfg_t = CW'(1); cfg_m = CW'(4);
    @(negedge clk);
    cfg_we = 1'b0;
    in_valid = 1'b1; in_inv = 1'b0; in_vec = '0; in_elem = LW'(1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 blocked request no result", int'(out_valid), 0);
    @(negedge clk);
    check("R9 idle out_valid low", int'(out_valid), 0);
    cur_t = 1; cur_m = 4;
    send(1'b0, 0, 1, 0, 0);
    check("R2 after blocked", int'(out_lane), 2);
  endtask

  task automatic t_same_cycle_cfg();
    write_cfg(1, 8);
    @(negedge clk);
    cfg_we = 1'b1; cfg_t = CW'(1); cfg_m = CW'(2);
    in_valid = 1'b1; in_inv = 1'b0; in_vec = '0; in_elem = LW'(1);
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    check("R9 same-cycle request accepted", int'(out_valid), 1);
    check("R9 same-cycle uses old cfg", int'(out_lane), 1);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_known_examples();
    t_fwd_sweep(1, 8);
    t_fwd_sweep(2, 4);
    t_fwd_sweep(3, 2);
    t_fwd_sweep(1, 7);
    t_inv_sweep(1, 5);
    t_inv_sweep(2, 3);
    t_inv_sweep(3, 2);
    t_inv_sweep(4, 2);
    t_out_of_range();
    t_rot();
    t_illegal();
    t_blocked();
    t_same_cycle_cfg();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule